// File: doc/BRIEF.md
# Asynchronous Receiver Transmitter with Break Control

This block is a byte-wide, bus-mapped serial port. A host writes a byte into a one-deep transmit buffer, and the block sends it as an asynchronous frame. The frame has one start bit, seven or eight data bits sent least-significant bit first, an optional odd or even parity bit, and one or two stop bits. The receive side rebuilds frames from a serial input into a data register. It raises an interrupt request while an unread byte is waiting.

Bit timing comes from two oversampling enables supplied from outside, one for receive and one for transmit. Each bit lasts `OVS` of these ticks. A command register enables the transmitter and receiver on their own. It can also force a break (line held low), and it clears the sticky error flags. While the transmitter is off, the line rests at mark. The block occupies three consecutive byte addresses starting at `BASE_ADDR`:

- offset 0: read receive data, write transmit data
- offset 1: read status, write mode
- offset 2: write command

Top module: `art_uart`

## Requirements
- R1: After reset, a data read returns 0xFF, a status read returns 0x00, `txd` is 1 and `irq` is 0.
- R2: The status byte at `BASE_ADDR+1` has these bits:
  - bit 0: transmitter enabled and transmit buffer empty
  - bit 1: received byte ready
  - bit 2: transmitter enabled, buffer empty and shifter idle
  - bit 3: parity error
  - bit 4: overrun
  - bit 5: framing error
  - bits 7:6: read as 0
- R3: A write to `BASE_ADDR+1` sets the mode:
  - bit 2 selects 8 data bits when set and 7 when clear
  - bit 3 selects two stop bits when set and one when clear
  - bit 4 enables parity
  - bit 5 selects even parity when set and odd when clear
- R4: A write to `BASE_ADDR+2` sets the command:
  - bit 0 enables the transmitter
  - bit 1 forces break
  - bit 2 enables the receiver
  - writing 1 to bit 4 clears the parity, overrun and framing flags
- R5: A transmitted frame has these fields in order: one start bit (0), the data bits LSB first, then the parity bit if parity is enabled, then the stop bits (1). Each bit lasts `OVS` transmit ticks.
- R6: A write to `BASE_ADDR` clears status bit 0 in the next cycle. The bit sets again once the byte moves into the shift register.
- R7: While the transmitter is enabled and break is set, `txd` is 0.
- R8: While the transmitter is disabled, `txd` is 1 whatever the state of the break bit.
- R9: The receiver samples each bit at the middle of its `OVS` ticks. A completed byte is loaded into the data register and sets status bit 1 and `irq`. In 7-bit mode, bit 7 of the read byte is 0.
- R10: A read of `BASE_ADDR` clears status bit 1 and `irq`.
- R11: If a byte completes while status bit 1 is still set, the overrun flag sets and the new byte replaces the old one.
- R12: The parity flag sets on a parity mismatch and the framing flag sets when the first stop bit samples 0. Both flags hold until they are cleared by command bit 4.
- R13: While the receiver is disabled, activity on `rxd` changes neither the data register, status bit 1 nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte bus address |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, valid while `busRd` is high |
| rxTick | input | 1 | Receive oversampling enable |
| txTick | input | 1 | Transmit oversampling enable |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq | output | 1 | High while a received byte is unread |

## Verification
The in-line assertions check the following on every cycle:
- a data read always drops the ready flag
- a completion onto an unread byte always raises overrun
- a data write always empties status bit 0 in the next cycle
- a disabled receiver never completes a byte
- every frame starts with a low start bit

Only the bench scenarios can show the rest:
- the exact bit order and parity value of transmitted frames under each mode
- mid-bit sampling of received frames
- the sticky errors and how they clear
- the 7-bit masking

A behavioural model of the line level, driven by the command writes, is compared with `txd` on every clock. It covers break and mark.

// File: rtl/art_pkg.sv
package art_pkg;

  localparam int DATA_MAX  = 8;
  localparam int FRAME_MAX = 1 + DATA_MAX + 1 + 2;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  // Control to datapath strobes and settings
  typedef struct packed {
    logic                txLoad;
    logic [DATA_MAX-1:0] txByte;
    logic                txEn;
    logic                brk;
    logic                rxEn;
    logic                eight;
    logic                twoStop;
    logic                parEn;
    logic                parEven;
  } ctrlStrobes_t;

  // Datapath back to control
  typedef struct packed {
    logic                txRdy;
    logic                txEmpty;
    logic                rxDone;
    logic [DATA_MAX-1:0] rxByte;
    logic                rxParErr;
    logic                rxFrmErr;
  } dpStatus_t;

  function automatic logic [FRAME_MAX-1:0] buildFrame(
    input logic [DATA_MAX-1:0] d,
    input logic eight,
    input logic parEn,
    input logic parEven
  );
    logic [FRAME_MAX-1:0] f;
    logic p;
    int nd;
    f  = '1;
    f[0] = 1'b0;
    nd = eight ? 8 : 7;
    p  = eight ? ^d : ^d[6:0];
    if (!parEven) p = ~p;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < nd) f[i+1] = d[i];
    end
    if (parEn) f[nd+1] = p;
    return f;
  endfunction

  function automatic logic [LEN_W-1:0] frameLen(
    input logic eight,
    input logic parEn,
    input logic twoStop
  );
    int n;
    n = 1 + (eight ? 8 : 7) + (parEn ? 1 : 0) + (twoStop ? 2 : 1);
    return LEN_W'(n);
  endfunction

endpackage

// File: rtl/art_ctrl.sv
module art_ctrl
  import art_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h14
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   busAddr,
  input  logic         busWr,
  input  logic         busRd,
  input  logic [7:0]   busWrData,
  output logic [7:0]   busRdData,
  input  dpStatus_t    dp,
  output ctrlStrobes_t cs,
  output logic         irq
);

  localparam logic [7:0] ADDR_DATA = BASE_ADDR;
  localparam logic [7:0] ADDR_STAT = BASE_ADDR + 8'd1;
  localparam logic [7:0] ADDR_CMD  = BASE_ADDR + 8'd2;

  logic selData, selStat, selCmd;
  logic rdData, errClr;

  logic modeEight, modeTwoStop, modeParEn, modeParEven;
  logic cmdTxEn, cmdBrk, cmdRxEn;
  logic [7:0] rxData;
  logic rxRdy, flagPe, flagOe, flagFe;
  logic [7:0] statusByte;

  assign selData = (busAddr == ADDR_DATA);
  assign selStat = (busAddr == ADDR_STAT);
  assign selCmd  = (busAddr == ADDR_CMD);
  assign rdData  = busRd && selData;
  assign errClr  = busWr && selCmd && busWrData[4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeEight   <= 1'b0;
      modeTwoStop <= 1'b0;
      modeParEn   <= 1'b0;
      modeParEven <= 1'b0;
      cmdTxEn     <= 1'b0;
      cmdBrk      <= 1'b0;
      cmdRxEn     <= 1'b0;
    end else begin
      if (busWr && selStat) begin
        modeEight   <= busWrData[2];
        modeTwoStop <= busWrData[3];
        modeParEn   <= busWrData[4];
        modeParEven <= busWrData[5];
      end
      if (busWr && selCmd) begin
        cmdTxEn <= busWrData[0];
        cmdBrk  <= busWrData[1];
        cmdRxEn <= busWrData[2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData <= 8'hFF;
      rxRdy  <= 1'b0;
      flagPe <= 1'b0;
      flagOe <= 1'b0;
      flagFe <= 1'b0;
    end else begin
      flagPe <= (errClr ? 1'b0 : flagPe) | (dp.rxDone & dp.rxParErr);
      flagFe <= (errClr ? 1'b0 : flagFe) | (dp.rxDone & dp.rxFrmErr);
      flagOe <= (errClr ? 1'b0 : flagOe) | (dp.rxDone & rxRdy & ~rdData);
      if (dp.rxDone) begin
        rxData <= dp.rxByte;
        rxRdy  <= 1'b1;
      end else if (rdData) begin
        rxRdy <= 1'b0;
      end
    end
  end

  assign statusByte = {2'b00, flagFe, flagOe, flagPe, dp.txEmpty, rxRdy, dp.txRdy};

  always_comb begin
    busRdData = 8'h00;
    if (busRd) begin
      if (selData)      busRdData = rxData;
      else if (selStat) busRdData = statusByte;
    end
  end

  assign irq = rxRdy;

  always_comb begin
    cs.txLoad  = busWr && selData;
    cs.txByte  = busWrData;
    cs.txEn    = cmdTxEn;
    cs.brk     = cmdBrk;
    cs.rxEn    = cmdRxEn;
    cs.eight   = modeEight;
    cs.twoStop = modeTwoStop;
    cs.parEn   = modeParEn;
    cs.parEven = modeParEven;
  end

  // R10
  rd_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData && !dp.rxDone) |=> !irq);

  // R11
  overrun_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dp.rxDone && irq && !rdData) |=> (flagOe && irq));

  // R6
  txload_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && selData && cmdTxEn && !(busWr && selCmd)) |=> !dp.txRdy);

endmodule

// File: rtl/art_datapath.sv
module art_datapath
  import art_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t cs,
  input  logic         rxTick,
  input  logic         txTick,
  input  logic         rxd,
  output logic         txd,
  output dpStatus_t    dp
);

  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);

  // Transmit side
  logic [DATA_MAX-1:0]  txBuf;
  logic                 bufFull;
  logic                 txBusy;
  logic [FRAME_MAX-1:0] shReg;
  logic [LEN_W-1:0]     bitsLeft;
  logic [CW-1:0]        txCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBuf    <= 8'hFF;
      bufFull  <= 1'b0;
      txBusy   <= 1'b0;
      shReg    <= '1;
      bitsLeft <= '0;
      txCnt    <= '0;
    end else begin
      if (cs.txLoad) begin
        txBuf   <= cs.txByte;
        bufFull <= 1'b1;
      end else if (bufFull && !txBusy && cs.txEn) begin
        shReg    <= buildFrame(txBuf, cs.eight, cs.parEn, cs.parEven);
        bitsLeft <= frameLen(cs.eight, cs.parEn, cs.twoStop);
        txCnt    <= '0;
        txBusy   <= 1'b1;
        bufFull  <= 1'b0;
      end
      if (txBusy && cs.txEn && txTick) begin
        txCnt <= txCnt + 1'b1;
        if (txCnt == LAST) begin
          shReg    <= {1'b1, shReg[FRAME_MAX-1:1]};
          bitsLeft <= bitsLeft - 1'b1;
          if (bitsLeft == LEN_W'(1)) txBusy <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    if (!cs.txEn)    txd = 1'b1;
    else if (cs.brk) txd = 1'b0;
    else if (txBusy) txd = shReg[0];
    else             txd = 1'b1;
  end

  // Receive side
  logic                rxBusy;
  logic [CW-1:0]       rxCnt;
  logic [LEN_W-1:0]    rxIdx;
  logic [DATA_MAX-1:0] rxSh;
  logic                parAcc;
  logic                rxDone, rxParErr, rxFrmErr;
  logic [LEN_W-1:0]    nData;

  assign nData = cs.eight ? LEN_W'(8) : LEN_W'(7);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBusy   <= 1'b0;
      rxCnt    <= '0;
      rxIdx    <= '0;
      rxSh     <= '0;
      parAcc   <= 1'b0;
      rxDone   <= 1'b0;
      rxParErr <= 1'b0;
      rxFrmErr <= 1'b0;
    end else begin
      rxDone <= 1'b0;
      if (!cs.rxEn) begin
        rxBusy <= 1'b0;
      end else if (rxTick) begin
        if (!rxBusy) begin
          if (!rxd) begin
            rxBusy <= 1'b1;
            rxCnt  <= '0;
            rxIdx  <= '0;
          end
        end else begin
          rxCnt <= rxCnt + 1'b1;
          if (rxCnt == MID) begin
            rxIdx <= rxIdx + 1'b1;
            if (rxIdx == '0) begin
              if (rxd) rxBusy <= 1'b0;
              rxSh   <= '0;
              parAcc <= 1'b0;
            end else if (rxIdx <= nData) begin
              rxSh[3'(rxIdx - 1'b1)] <= rxd;
              parAcc <= parAcc ^ rxd;
            end else if (cs.parEn && rxIdx == nData + 1'b1) begin
              parAcc <= parAcc ^ rxd;
            end else begin
              rxBusy   <= 1'b0;
              rxDone   <= 1'b1;
              rxFrmErr <= ~rxd;
              rxParErr <= cs.parEn & (parAcc ~^ cs.parEven);
            end
          end
        end
      end
    end
  end

  always_comb begin
    dp.txRdy    = cs.txEn & ~bufFull;
    dp.txEmpty  = cs.txEn & ~bufFull & ~txBusy;
    dp.rxDone   = rxDone;
    dp.rxByte   = rxSh;
    dp.rxParErr = rxParErr;
    dp.rxFrmErr = rxFrmErr;
  end

  // R13
  rx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cs.rxEn |=> !rxDone);

  // R5
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txBusy) && cs.txEn && !cs.brk) |-> !txd);

  // R6
  handoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !txBusy && cs.txEn && !cs.txLoad) |=> (!bufFull && txBusy));

endmodule

// File: rtl/art_uart.sv
module art_uart
  import art_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h14,
  parameter int         OVS       = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic       rxTick,
  input  logic       txTick,
  input  logic       rxd,
  output logic       txd,
  output logic       irq
);

  ctrlStrobes_t csBus;
  dpStatus_t    dpBus;

  art_ctrl #(.BASE_ADDR(BASE_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .dp(dpBus), .cs(csBus), .irq(irq)
  );

  art_datapath #(.OVS(OVS)) uDp (
    .clk(clk), .rstN(rstN), .cs(csBus), .rxTick(rxTick), .txTick(txTick),
    .rxd(rxd), .txd(txd), .dp(dpBus)
  );

endmodule

// File: tb/sim_art_uart.sv
`timescale 1ns/1ps
module sim_art_uart;

  localparam logic [7:0] A_DATA = 8'h14;
  localparam logic [7:0] A_STAT = 8'h15;
  localparam logic [7:0] A_CMD  = 8'h16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic rxTick = 1'b1, txTick = 1'b1;
  logic rxd = 1'b1;
  logic txd, irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit mdlTxEn = 1'b0, mdlBrk = 1'b0;

  always #2.5 clk = ~clk;

  art_uart u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .rxTick(rxTick), .txTick(txTick),
    .rxd(rxd), .txd(txd), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Every-clock line model for break and mark (R7, R8)
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (!mdlTxEn)   chk("R8 line mark", {15'd0, txd}, 16'd1);
      else if (mdlBrk) chk("R7 line break", {15'd0, txd}, 16'd0);
    end
  end

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
    if (a == A_CMD) begin
      mdlTxEn = d[0];
      mdlBrk  = d[1];
    end
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdData;
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendRx(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = bits[i];
      repeat (16) @(posedge clk);
      #1;
    end
    rxd = 1'b1;
  endtask

  task automatic decodeTx(input int n, output logic [15:0] bits);
    bits = '1;
    @(negedge clk);
    while (txd) @(negedge clk);
    repeat (8) @(negedge clk);
    bits[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (16) @(negedge clk);
      bits[i] = txd;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [15:0] b;
    idle(4);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    busRead(A_STAT, r); chk("R1 status", {8'd0, r}, 16'h00);
    busRead(A_DATA, r); chk("R1 data", {8'd0, r}, 16'hFF);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 txd", {15'd0, txd}, 16'd1);

    // R3 R4 8N1, both enabled
    busWrite(A_STAT, 8'h04);
    busWrite(A_CMD, 8'h05);
    busRead(A_STAT, r); chk("R2 idle enabled status", {8'd0, r}, 16'h05);

    // R5 R6 8N1 transmit
    busWrite(A_DATA, 8'hA5);
    busRead(A_STAT, r); chk("R6 buffer full", {8'd0, r}, 16'h00);
    idle(3);
    busRead(A_STAT, r); chk("R6 hand-off", {8'd0, r}, 16'h01);
    decodeTx(10, b); chk("R5 frame 8N1", b & 16'h03FF, {6'd0, 1'b1, 8'hA5, 1'b0});
    idle(12);
    busRead(A_STAT, r); chk("R2 txEmpty back", {8'd0, r}, 16'h05);

    // R5 7E1 transmit: 0x35 has four ones, parity 0
    busWrite(A_STAT, 8'h30);
    busWrite(A_DATA, 8'h35);
    decodeTx(10, b); chk("R5 frame 7E1", b & 16'h03FF, {6'd0, 1'b1, 1'b0, 7'h35, 1'b0});
    idle(12);

    // R3 8O2 transmit: 0x00 odd parity 1, two stops
    busWrite(A_STAT, 8'h1C);
    busWrite(A_DATA, 8'h00);
    decodeTx(12, b); chk("R3 frame 8O2", b & 16'h0FFF, {4'd0, 2'b11, 1'b1, 8'h00, 1'b0});
    idle(30);

    // R9 R10 receive 8N1
    busWrite(A_STAT, 8'h04);
    sendRx({6'd0, 1'b1, 8'h3C, 1'b0}, 10);
    idle(2);
    chk("R9 irq set", {15'd0, irq}, 16'd1);
    busRead(A_STAT, r); chk("R9 status ready", {8'd0, r}, 16'h07);
    busRead(A_DATA, r); chk("R9 data", {8'd0, r}, 16'h3C);
    busRead(A_STAT, r); chk("R10 ready cleared", {8'd0, r}, 16'h05);
    chk("R10 irq cleared", {15'd0, irq}, 16'd0);

    // R11 overrun
    sendRx({6'd0, 1'b1, 8'h11, 1'b0}, 10);
    sendRx({6'd0, 1'b1, 8'h22, 1'b0}, 10);
    idle(2);
    busRead(A_STAT, r); chk("R11 overrun status", {8'd0, r}, 16'h17);
    busRead(A_DATA, r); chk("R11 newest byte", {8'd0, r}, 16'h22);
    busWrite(A_CMD, 8'h15);
    busRead(A_STAT, r); chk("R4 error clear", {8'd0, r}, 16'h05);

    // R12 parity error, 8O1 with wrong parity bit
    busWrite(A_STAT, 8'h14);
    sendRx({5'd0, 1'b1, 1'b1, 8'h01, 1'b0}, 11);
    idle(2);
    busRead(A_STAT, r); chk("R12 parity flag", {8'd0, r}, 16'h0F);
    busRead(A_DATA, r); chk("R12 parity data", {8'd0, r}, 16'h01);
    busWrite(A_CMD, 8'h15);

    // R12 parity good, no flag
    sendRx({5'd0, 1'b1, 1'b0, 8'h01, 1'b0}, 11);
    idle(2);
    busRead(A_STAT, r); chk("R12 parity ok", {8'd0, r}, 16'h07);
    busRead(A_DATA, r);

    // R12 framing error
    busWrite(A_STAT, 8'h04);
    sendRx({6'd0, 1'b0, 8'h5A, 1'b0}, 10);
    idle(40);
    busRead(A_STAT, r); chk("R12 framing flag", {8'd0, r}, 16'h27);
    busRead(A_DATA, r); chk("R12 framing data", {8'd0, r}, 16'h5A);
    busWrite(A_CMD, 8'h15);

    // R9 7-bit receive
    busWrite(A_STAT, 8'h00);
    sendRx({7'd0, 1'b1, 7'h7F, 1'b0}, 9);
    idle(2);
    busRead(A_DATA, r); chk("R9 7-bit data", {8'd0, r}, 16'h7F);

    // R13 receiver disabled
    busWrite(A_STAT, 8'h04);
    busWrite(A_CMD, 8'h01);
    sendRx({6'd0, 1'b1, 8'h99, 1'b0}, 10);
    idle(2);
    chk("R13 irq quiet", {15'd0, irq}, 16'd0);
    busRead(A_STAT, r); chk("R13 status", {8'd0, r}, 16'h05);
    busRead(A_DATA, r); chk("R13 data kept", {8'd0, r}, 16'h7F);

    // R7 break, R8 mark
    busWrite(A_CMD, 8'h03);
    idle(3);
    chk("R7 break low", {15'd0, txd}, 16'd0);
    busWrite(A_CMD, 8'h02);
    idle(3);
    chk("R8 disabled over break", {15'd0, txd}, 16'd1);
    busRead(A_STAT, r); chk("R2 disabled status", {8'd0, r}, 16'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule